// File: doc/BRIEF.md
# Colour Look-up Table Loader

This block holds a 256-entry colour table, each entry an 8-bit red, green and blue triple. A processor fills it through a 16-byte register window on a plain 32-bit write/read bus. One register selects the entry to load. Another register, the data port, takes the three colour components of that entry in turn.

A short phase counter decides which component the next data write lands in. After the third component it moves the entry pointer forward by one. A whole table, or any run of consecutive entries, can therefore be loaded with one pointer write followed by a stream of data writes.

A separate read port serves the pixel pipeline. It returns the 24-bit colour of any entry combinationally, so the pipeline can use it in the same cycle it presents the index.

Top module: `clut_loader`

## Requirements
- R1: The table has 256 entries of three 8-bit components. `pix_rgb_o` returns red in bits 23:16, green in 15:8 and blue in 7:0 for the entry selected by `pix_idx_i`, combinationally in the same cycle.
- R2: A write to offset 0 loads the entry pointer from bits 31:24 of the write data and returns the component phase to red.
- R3: Each write to offset 4 stores bits 31:24 of the write data into one component of the pointed entry. The first goes to red, the second to green and the third to blue.
- R4: The write that stores blue also advances the pointer by one, wrapping from 255 to 0, and returns the phase to red.
- R5: Writes to offsets 8 and 12 change no entry, and they leave the pointer and the phase unchanged.
- R6: `bus_rdata_o` reads zero at every offset.
- R7: After reset, entry 255 is white (all components 255) and every other entry is black. The pointer and the phase are both zero.
- R8: Address bits 1:0 and the byte enables are ignored. Every write is decoded by its word offset and acts as a full 32-bit write.
- R9: When a data write and a colour read hit the same entry in one cycle, the read returns the old colour. The new colour appears after that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | 4 | Byte offset in the register window |
| bus_be_i | input | 4 | Byte enables (ignored) |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, always zero |
| pix_idx_i | input | 8 | Colour read index |
| pix_rgb_o | output | 24 | Colour of the indexed entry |

## Verification
The bench loads all 768 components with an arithmetic pattern and sweeps every index, so a mis-ordered component or a pointer that skips would corrupt some entry. It drives the pointer across 255 to 0 to catch a pointer that saturates or a phase that fails to clear. It also rewrites the pointer in the middle of an entry to catch a phase that keeps counting from where it was. Writes to the unused offsets, to unaligned addresses and with byte enables cleared show whether the decoder mistakes them for pointer or data writes. A same-cycle read and write of one entry shows whether the write leaks through to the read port combinationally.

// File: rtl/clut_pkg.sv
package clut_pkg;
  typedef enum logic [1:0] {
    PH_RED   = 2'd0,
    PH_GREEN = 2'd1,
    PH_BLUE  = 2'd2
  } comp_e;
endpackage

// File: rtl/clut_seq.sv
module clut_seq
  import clut_pkg::*;
#(
  parameter int WORD_W = 2,
  parameter int IDX_W  = 8,
  parameter int COMP_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [IDX_W-1:0]  idx_val_i,
  input  logic [COMP_W-1:0] comp_val_i,
  output logic              wr_en_o,
  output comp_e             wr_sel_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [COMP_W-1:0] wr_val_o
);
  localparam logic [WORD_W-1:0] WORD_IDX = WORD_W'(0);
  localparam logic [WORD_W-1:0] WORD_DAT = WORD_W'(1);

  logic             hit_idx, hit_dat;
  logic [IDX_W-1:0] idx_q;
  comp_e            ph_q;

  assign hit_idx = wr_i && (word_i == WORD_IDX);
  assign hit_dat = wr_i && (word_i == WORD_DAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      ph_q  <= PH_RED;
    end else if (hit_idx) begin
      idx_q <= idx_val_i;
      ph_q  <= PH_RED;
    end else if (hit_dat) begin
      unique case (ph_q)
        PH_RED:   ph_q <= PH_GREEN;
        PH_GREEN: ph_q <= PH_BLUE;
        default: begin
          ph_q  <= PH_RED;
          idx_q <= idx_q + 1'b1;  // wraps modulo table size
        end
      endcase
    end
  end

  assign wr_en_o  = hit_dat;
  assign wr_sel_o = ph_q;
  assign wr_idx_o = idx_q;
  assign wr_val_o = comp_val_i;

  a_r3_phase_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_q != comp_e'(2'd3));

  a_r2_index_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_idx |=> (ph_q == PH_RED) && (idx_q == $past(idx_val_i)));

  a_r3_red_then_green: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_dat && ph_q == PH_RED) |=> (ph_q == PH_GREEN) && $stable(idx_q));

  a_r4_blue_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_dat && ph_q == PH_BLUE) |=> (ph_q == PH_RED) && (idx_q == $past(idx_q) + 1'b1));

  a_r5_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hit_idx && !hit_dat) |=> $stable(idx_q) && $stable(ph_q));
endmodule

// File: rtl/clut_store.sv
module clut_store
  import clut_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  comp_e               wr_sel_i,
  input  logic [IDX_W-1:0]    wr_idx_i,
  input  logic [COMP_W-1:0]   wr_val_i,
  input  logic [IDX_W-1:0]    rd_idx_i,
  output logic [3*COMP_W-1:0] rd_rgb_o
);
  localparam int ENTRIES = 1 << IDX_W;

  for (genvar c = 0; c < 3; c++) begin : g_plane
    localparam comp_e SEL = comp_e'(c);
    logic [COMP_W-1:0] plane_q [ENTRIES];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int e = 0; e < ENTRIES; e++)
          plane_q[e] <= (e == ENTRIES - 1) ? '1 : '0;
      end else if (wr_en_i && wr_sel_i == SEL) begin
        plane_q[wr_idx_i] <= wr_val_i;
      end
    end

    // red in the top slice, blue in the bottom
    assign rd_rgb_o[(2-c)*COMP_W +: COMP_W] = plane_q[rd_idx_i];
  end

  a_r9_no_write_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!wr_en_i) && $stable(rd_idx_i)) |-> $stable(rd_rgb_o));
endmodule

// File: rtl/clut_loader.sv
module clut_loader #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 8,
  parameter int COMP_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bus_wr_i,
  input  logic                bus_rd_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [DATA_W/8-1:0] bus_be_i,
  input  logic [DATA_W-1:0]   bus_wdata_i,
  output logic [DATA_W-1:0]   bus_rdata_o,
  input  logic [IDX_W-1:0]    pix_idx_i,
  output logic [3*COMP_W-1:0] pix_rgb_o
);
  import clut_pkg::*;
  localparam int WORD_W = ADDR_W - 2;

  logic              wr_en;
  comp_e             wr_sel;
  logic [IDX_W-1:0]  wr_idx;
  logic [COMP_W-1:0] wr_val;
  logic              unused_ok;

  assign unused_ok   = ^{bus_rd_i, bus_be_i, bus_addr_i[1:0], bus_wdata_i};
  assign bus_rdata_o = '0;

  clut_seq #(.WORD_W(WORD_W), .IDX_W(IDX_W), .COMP_W(COMP_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (bus_wr_i),
    .word_i     (bus_addr_i[ADDR_W-1:2]),
    .idx_val_i  (bus_wdata_i[DATA_W-1 -: IDX_W]),
    .comp_val_i (bus_wdata_i[DATA_W-1 -: COMP_W]),
    .wr_en_o    (wr_en),
    .wr_sel_o   (wr_sel),
    .wr_idx_o   (wr_idx),
    .wr_val_o   (wr_val)
  );

  clut_store #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .wr_sel_i (wr_sel),
    .wr_idx_i (wr_idx),
    .wr_val_i (wr_val),
    .rd_idx_i (pix_idx_i),
    .rd_rgb_o (pix_rgb_o)
  );

  a_r5_spare_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_addr_i[ADDR_W-1:2] > WORD_W'(1)) |-> !wr_en);
endmodule

// File: tb/sim_clut_loader.sv
module sim_clut_loader;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_wr_i = 1'b0, bus_rd_i = 1'b0;
  logic [3:0]  bus_addr_i = '0;
  logic [3:0]  bus_be_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic [7:0]  pix_idx_i = '0;
  logic [23:0] pix_rgb_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  clut_loader u0 (
    .clk_i(clk), .rst_ni(rst_ni), .bus_wr_i(bus_wr_i), .bus_rd_i(bus_rd_i),
    .bus_addr_i(bus_addr_i), .bus_be_i(bus_be_i), .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o), .pix_idx_i(pix_idx_i), .pix_rgb_o(pix_rgb_o)
  );

  function automatic logic [23:0] pat(int i);
    return {8'(i), 8'(i ^ 8'h5A), 8'(255 - i)};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] top, input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_wr_i = 1'b1; bus_addr_i = a; bus_be_i = be; bus_wdata_i = {top, 24'h3C_A5_0F};
    @(negedge clk);
    bus_wr_i = 1'b0; bus_wdata_i = '0;
  endtask

  task automatic look(input string req, input int idx, input logic [23:0] exp);
    pix_idx_i = 8'(idx);
    #1;
    chk(req, {8'h0, pix_rgb_o}, {8'h0, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=hung exp=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R7: reset contents
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      look("R7", i, (i == 255) ? 24'hFFFFFF : 24'h0);
    end
    // R7: pointer and phase start at zero
    wr(4'd4, 8'h11);
    look("R7", 0, 24'h110000);

    // R1/R3: full load from pointer 0
    wr(4'd0, 8'd0);
    for (int i = 0; i < 256; i++) begin
      wr(4'd4, pat(i)[23:16]);
      wr(4'd4, pat(i)[15:8]);
      wr(4'd4, pat(i)[7:0]);
    end
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      look("R3", i, pat(i));
    end

    // R4: pointer wrapped to 0 after full load
    wr(4'd4, 8'hAA);
    look("R4", 0, {8'hAA, pat(0)[15:0]});
    wr(4'd0, 8'd255);
    wr(4'd4, 8'h01); wr(4'd4, 8'h02); wr(4'd4, 8'h03);
    look("R4", 255, 24'h010203);
    wr(4'd4, 8'h77);
    look("R4", 0, {8'h77, pat(0)[15:0]});

    // R2: pointer write mid-entry resets phase
    wr(4'd0, 8'd10);
    wr(4'd4, 8'hC1);
    wr(4'd0, 8'd10);
    wr(4'd4, 8'hC2); wr(4'd4, 8'hC3); wr(4'd4, 8'hC4);
    look("R2", 10, 24'hC2C3C4);
    look("R2", 11, pat(11));

    // R5: spare offsets do nothing
    wr(4'd0, 8'd20);
    wr(4'd4, 8'hD1);
    wr(4'd8, 8'h99);
    wr(4'd12, 8'h9A);
    look("R5", 20, {8'hD1, pat(20)[15:0]});
    wr(4'd4, 8'hD2); wr(4'd4, 8'hD3);
    look("R5", 20, 24'hD1D2D3);
    look("R5", 21, pat(21));
    look("R5", 8'h99, pat(8'h99));

    // R8: unaligned address, byte enables cleared
    wr(4'd1, 8'd30, 4'h0);
    wr(4'd7, 8'hE1, 4'h0); wr(4'd6, 8'hE2, 4'h1); wr(4'd5, 8'hE3, 4'h0);
    look("R8", 30, 24'hE1E2E3);

    // R6: reads return zero
    for (int a = 0; a < 16; a += 4) begin
      @(negedge clk);
      bus_rd_i = 1'b1; bus_addr_i = 4'(a);
      #1;
      chk("R6", bus_rdata_o, 32'h0);
    end
    @(negedge clk);
    bus_rd_i = 1'b0;

    // R9: same-cycle write/read returns old value
    wr(4'd0, 8'd40);
    @(negedge clk);
    pix_idx_i = 8'd40;
    bus_wr_i = 1'b1; bus_addr_i = 4'd4; bus_be_i = 4'hF; bus_wdata_i = 32'h5F00_0000;
    #1;
    chk("R9", {8'h0, pix_rgb_o}, {8'h0, pat(40)});
    @(negedge clk);
    bus_wr_i = 1'b0; bus_wdata_i = '0;
    #1;
    chk("R9", {8'h0, pix_rgb_o}, {8'h0, 8'h5F, pat(40)[15:0]});

    // R1: combinational index change within a cycle
    @(negedge clk);
    pix_idx_i = 8'd255;
    #1;
    chk("R1", {8'h0, pix_rgb_o}, 32'h010203);
    pix_idx_i = 8'd100;
    #1;
    chk("R1", {8'h0, pix_rgb_o}, {8'h0, pat(100)});

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule